// File: doc/BRIEF.md
# Interrupt Acknowledge Timing Controller

This block decides on which instruction boundary a pending interrupt request is accepted. The CPU pulses `instr_start` in the first clock of every instruction and supplies that instruction's length in clocks (4 to 10). Sources set their request flags with one-clock pulses on `req_set`. Each flag can be masked and carries a fixed priority value.

At the end of each instruction the block picks the most urgent unmasked pending request. It takes that request when all of the following hold: interrupts are globally enabled, the flag and mask registers are not being accessed, and the request outranks whatever is already being serviced. It then runs an 8-clock sequence: status save, program-counter save, and vector load.

A request raised in the final clock of an instruction misses that boundary. It is taken at the end of the next instruction. A small stack of in-service priorities supports nesting and is popped by the return strobe `reti`. All pins are plain control and status signals. There is no streaming interface, so no back-pressure applies.

Top module: `iat_ctrl`

## Requirements
- R1: After reset, `ack`, `busy` and all phase outputs are 0, `pend` is all zeros and `ie` is 1.
- R2: A `req_set` pulse in any clock 1 to n−1 of an n-clock instruction (n = 4..10) makes `ack` high, with the source on `ack_id`, in the clock right after clock n.
- R3: A `req_set` pulse in clock n of an instruction gives no acknowledge at that boundary; `ack` rises in the clock after the final clock of the following instruction.
- R4: The acknowledge sequence lasts 8 clocks with `busy` high. `ack` is high in clock 1 only. `save_psw` is high in clocks 1–3, `save_pc` in clocks 4–6 and `vec_load` in clocks 7–8. `ack_id` is held for the whole sequence.
- R5: The acknowledged source's `pend` bit reads 0 from clock 1 of the sequence.
- R6: If `reg_access` is high in the final clock of an instruction, nothing is taken at that boundary and the request stays pending.
- R7: A source whose `mask` bit is 1 is never acknowledged; its flag stays pending until it is unmasked.
- R8: Among unmasked pending sources, the one with the largest priority value wins. Source i's priority is `prio_vec[i*PW +: PW]`. Ties go to the lowest source index.
- R9: `ie` is cleared by an acknowledge and set by `ei_set` or `reti`. While `ie` is 0 nothing is taken.
- R10: A request nests only if its priority is strictly greater than the top of the in-service stack. `reti` pops one stack entry.
- R11: `instr_start` pulses while `busy` is high are ignored, so they never create an instruction boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_start | input | 1 | First clock of an instruction |
| instr_len | input | 4 | Instruction length in clocks, valid with `instr_start` |
| req_set | input | NSRC | One-clock pulses that set request flags |
| mask | input | NSRC | 1 blocks the source |
| prio_vec | input | NSRC*PW | Per-source priority values, larger is more urgent |
| reg_access | input | 1 | Flag or mask registers are being accessed |
| ei_set | input | 1 | Sets the global enable |
| reti | input | 1 | Return from service: pops the stack and sets the enable |
| ack | output | 1 | Acknowledge pulse, clock 1 of the sequence |
| ack_id | output | IW | Acknowledged source index |
| busy | output | 1 | 8-clock save/jump window |
| save_psw | output | 1 | Status-save phase |
| save_pc | output | 1 | Program-counter-save phase |
| vec_load | output | 1 | Vector-load phase |
| pend | output | NSRC | Pending request flags |
| ie | output | 1 | Global interrupt enable |

## Verification
The hardest case to reach is an `instr_start` pulse that arrives inside the busy window while a higher-priority request is pending and the enable has just been restored. That pulse would make a boundary a few clocks after `busy` falls. The bench raises the request and `ei_set` in the third sequence clock and pulses `instr_start` in the eighth. It then watches six clocks for a spurious acknowledge before issuing a real instruction. The full boundary sweep drives requests in clocks 1, n−1 and n for every n from 4 to 10, using a vector table. Nesting is exercised by acknowledging a low source, nesting a high one, and then showing that a lower request waits through two returns.

// File: rtl/iat_pkg.sv
package iat_pkg;
  localparam int unsigned LEN_W    = 4;
  localparam int unsigned SEQ_CLKS = 8;
  localparam int unsigned PSW_LAST = 3;
  localparam int unsigned PC_LAST  = 6;
  localparam int unsigned SEQ_W    = $clog2(SEQ_CLKS + 1);
  typedef logic [LEN_W-1:0] ilen_t;
  typedef logic [SEQ_W-1:0] seq_t;
endpackage

// File: rtl/iat_instr_timer.sv
module iat_instr_timer
  import iat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  ilen_t len,
  input  logic  busy,
  output logic  last
);
  logic  run_q;
  ilen_t len_q, cnt_q, len_now, pos_now;
  logic  go;

  assign go = start & ~busy;

  always_comb begin
    len_now = go ? len : len_q;
    pos_now = go ? ilen_t'(1) : cnt_q + ilen_t'(1);
  end

  assign last = (go | run_q) & (pos_now == len_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      len_q <= '0;
      cnt_q <= '0;
    end else if (go | run_q) begin
      cnt_q <= pos_now;
      run_q <= ~last;
      if (go) len_q <= len;
    end
  end

  // R11
  timer_quiet_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !last);
endmodule

// File: rtl/iat_arbiter.sv
module iat_arbiter #(
  parameter int NSRC = 4,
  parameter int PW   = 2,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]    cand,
  input  logic [NSRC*PW-1:0] prio_vec,
  output logic               valid,
  output logic [IW-1:0]      id,
  output logic [PW-1:0]      prio
);
  logic [PW-1:0] p [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_unpack
    assign p[g] = prio_vec[g*PW +: PW];
  end

  always_comb begin
    valid = 1'b0;
    id    = '0;
    prio  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!valid || p[i] > prio)) begin
        valid = 1'b1;
        id    = IW'(i);
        prio  = p[i];
      end
    end
  end

  // R8
  always_comb begin
    win_is_cand_chk: assert (!valid || cand[id]);
  end
endmodule

// File: rtl/iat_nest_stack.sv
module iat_nest_stack #(
  parameter int DEPTH = 4,
  parameter int PW    = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] top,
  output logic          empty,
  output logic          full
);
  logic [PW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp_q;
  logic [AW-1:0]  top_idx;

  assign empty   = (sp_q == '0);
  assign full    = (sp_q == SPW'(DEPTH));
  assign top_idx = AW'(sp_q - SPW'(1));
  assign top     = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (push && pop && !empty) mem[top_idx] <= din;
    else if (push && !full)    mem[AW'(sp_q)] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else if (push && pop && !empty) sp_q <= sp_q;
    else if (push && !full)         sp_q <= sp_q + SPW'(1);
    else if (pop && !empty)         sp_q <= sp_q - SPW'(1);
  end

  // R10
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
endmodule

// File: rtl/iat_seq.sv
module iat_seq
  import iat_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [IW-1:0] id_in,
  output logic          ack,
  output logic [IW-1:0] ack_id,
  output logic          busy,
  output logic          save_psw,
  output logic          save_pc,
  output logic          vec_load
);
  seq_t cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ack_id <= '0;
    end else if (take) begin
      cnt_q  <= seq_t'(1);
      ack_id <= id_in;
    end else if (cnt_q != '0) begin
      cnt_q <= (cnt_q == seq_t'(SEQ_CLKS)) ? '0 : cnt_q + seq_t'(1);
    end
  end

  assign busy     = (cnt_q != '0);
  assign ack      = (cnt_q == seq_t'(1));
  assign save_psw = busy && (cnt_q <= seq_t'(PSW_LAST));
  assign save_pc  = (cnt_q > seq_t'(PSW_LAST)) && (cnt_q <= seq_t'(PC_LAST));
  assign vec_load = (cnt_q > seq_t'(PC_LAST));

  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!ack && save_psw));
  // R4
  psw_then_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(save_psw) |-> save_pc);
  // R4
  ends_after_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(vec_load));
  // R4
  id_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack) |-> $stable(ack_id));
  // R11
  take_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !busy);
endmodule

// File: rtl/iat_ctrl.sv
module iat_ctrl
  import iat_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int PW    = 2,
  parameter int DEPTH = 4,
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_start,
  input  logic [LEN_W-1:0]   instr_len,
  input  logic [NSRC-1:0]    req_set,
  input  logic [NSRC-1:0]    mask,
  input  logic [NSRC*PW-1:0] prio_vec,
  input  logic               reg_access,
  input  logic               ei_set,
  input  logic               reti,
  output logic               ack,
  output logic [IW-1:0]      ack_id,
  output logic               busy,
  output logic               save_psw,
  output logic               save_pc,
  output logic               vec_load,
  output logic [NSRC-1:0]    pend,
  output logic               ie
);
  logic [NSRC-1:0] pend_q, clr, mask_d;
  logic            ie_q, last, win_valid, take, stk_empty, stk_full;
  logic [IW-1:0]   win_id;
  logic [PW-1:0]   win_prio, top_prio;

  iat_instr_timer u_timer (
    .clk(clk), .rst_n(rst_n), .start(instr_start), .len(instr_len),
    .busy(busy), .last(last)
  );

  iat_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
    .cand(pend_q & ~mask), .prio_vec(prio_vec),
    .valid(win_valid), .id(win_id), .prio(win_prio)
  );

  iat_nest_stack #(.DEPTH(DEPTH), .PW(PW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(take), .pop(reti), .din(win_prio),
    .top(top_prio), .empty(stk_empty), .full(stk_full)
  );

  iat_seq #(.IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .id_in(win_id),
    .ack(ack), .ack_id(ack_id), .busy(busy),
    .save_psw(save_psw), .save_pc(save_pc), .vec_load(vec_load)
  );

  assign take = last && !busy && win_valid && ie_q && !reg_access && !stk_full
                && (stk_empty || (win_prio > top_prio));
  assign clr  = take ? (NSRC'(1) << win_id) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ie_q   <= 1'b1;
      mask_d <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | req_set;
      mask_d <= mask;
      if (take)                ie_q <= 1'b0;
      else if (ei_set || reti) ie_q <= 1'b1;
    end
  end

  assign pend = pend_q;
  assign ie   = ie_q;

  // R2
  ack_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(last));
  // R5
  flag_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_set[win_id]) |=> !pend_q[$past(win_id)]);
  // R6
  hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !$past(reg_access));
  // R7
  masked_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !mask_d[ack_id]);
  // R9
  ie_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !ie_q);
endmodule

// File: tb/tb_iat_ctrl.sv
module tb_iat_ctrl;
  localparam int NSRC = 4, PW = 2, DEPTH = 4, IW = 2;
  localparam int NV = 21;
  // {defer, len, request clock}
  localparam logic [8:0] VEC [NV] = '{
    {1'b0,4'd4,4'd1},  {1'b0,4'd4,4'd3},  {1'b1,4'd4,4'd4},
    {1'b0,4'd5,4'd1},  {1'b0,4'd5,4'd4},  {1'b1,4'd5,4'd5},
    {1'b0,4'd6,4'd1},  {1'b0,4'd6,4'd5},  {1'b1,4'd6,4'd6},
    {1'b0,4'd7,4'd1},  {1'b0,4'd7,4'd6},  {1'b1,4'd7,4'd7},
    {1'b0,4'd8,4'd1},  {1'b0,4'd8,4'd7},  {1'b1,4'd8,4'd8},
    {1'b0,4'd9,4'd1},  {1'b0,4'd9,4'd8},  {1'b1,4'd9,4'd9},
    {1'b0,4'd10,4'd1}, {1'b0,4'd10,4'd9}, {1'b1,4'd10,4'd10}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_start = 0, reg_access = 0, ei_set = 0, reti = 0;
  logic [3:0] instr_len = 4'd4;
  logic [NSRC-1:0] req_set = '0, mask = '0;
  logic [NSRC*PW-1:0] prio_vec = '0;
  logic ack, busy, save_psw, save_pc, vec_load, ie;
  logic [IW-1:0] ack_id;
  logic [NSRC-1:0] pend;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  iat_ctrl #(.NSRC(NSRC), .PW(PW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .instr_start(instr_start), .instr_len(instr_len),
    .req_set(req_set), .mask(mask), .prio_vec(prio_vec), .reg_access(reg_access),
    .ei_set(ei_set), .reti(reti), .ack(ack), .ack_id(ack_id), .busy(busy),
    .save_psw(save_psw), .save_pc(save_pc), .vec_load(vec_load), .pend(pend), .ie(ie)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    instr_start = 0; req_set = '0; reg_access = 0; ei_set = 0; reti = 0;
  endtask

  task automatic instr(input int len, input int rclk, input int rsrc, input bit hold);
    for (int c = 1; c <= len; c++) begin
      @(negedge clk);
      idle();
      instr_start = (c == 1);
      instr_len   = 4'(len);
      if (c == rclk) req_set = 4'(1) << rsrc;
      reg_access = hold && (c == len);
    end
    @(negedge clk);
    idle();
  endtask

  task automatic finish_seq();
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_reti();
    @(negedge clk); idle(); reti = 1;
    @(negedge clk); idle();
  endtask

  task automatic pulse_ei();
    @(negedge clk); idle(); ei_set = 1;
    @(negedge clk); idle();
  endtask

  task automatic do_reset();
    rst_n = 0; idle(); mask = '0; prio_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk(ack == 0 && busy == 0 && save_psw == 0 && save_pc == 0 && vec_load == 0,
        "R1", int'({ack, busy, save_psw, save_pc, vec_load}), 0);
    chk(pend == '0, "R1", int'(pend), 0);
    chk(ie == 1, "R1", int'(ie), 1);

    // R2 / R3 boundary sweep
    for (int v = 0; v < NV; v++) begin
      int len, rc;
      bit df;
      df  = VEC[v][8];
      len = int'(VEC[v][7:4]);
      rc  = int'(VEC[v][3:0]);
      instr(len, rc, 0, 0);
      if (df) begin
        chk(ack == 0, "R3", int'(ack), 0);
        instr(4, 0, 0, 0);
      end
      chk(ack == 1 && ack_id == 0, df ? "R3" : "R2", int'(ack), 1);
      finish_seq();
      pulse_reti();
    end

    // R4, R5, R9, R10, R11: sequence shape, start ignored while busy, nesting
    do_reset();
    prio_vec = {2'd0, 2'd3, 2'd1, 2'd0};
    instr(5, 2, 1, 0);
    chk(ack == 1 && ack_id == 1 && save_psw == 1, "R4", int'(ack_id), 1);
    chk(pend[1] == 0, "R5", int'(pend[1]), 0);
    chk(ie == 0, "R9", int'(ie), 0);
    for (int s = 2; s <= 9; s++) begin
      logic [4:0] expv;
      @(negedge clk);
      idle();
      expv = {1'(s <= 8), 1'(s <= 3), 1'(s >= 4 && s <= 6), 1'(s >= 7 && s <= 8), 1'b0};
      chk({busy, save_psw, save_pc, vec_load, ack} == expv && ack_id == 1, "R4",
          int'({busy, save_psw, save_pc, vec_load, ack}), int'(expv));
      if (s == 3) begin req_set = 4'b0100; ei_set = 1; end
      if (s == 8) begin instr_start = 1; instr_len = 4'd4; end
    end
    for (int s = 10; s <= 15; s++) begin
      @(negedge clk);
      idle();
      chk(ack == 0, "R11", int'(ack), 0);
    end
    instr(4, 0, 0, 0);
    chk(ack == 1 && ack_id == 2, "R10", int'(ack_id), 2);
    finish_seq();
    pulse_ei();
    instr(4, 1, 0, 0);
    chk(ack == 0, "R10", int'(ack), 0);
    pulse_reti();
    instr(4, 0, 0, 0);
    chk(ack == 0, "R10", int'(ack), 0);
    pulse_reti();
    instr(4, 0, 0, 0);
    chk(ack == 1 && ack_id == 0, "R10", int'(ack), 1);

    // R9: enable low blocks
    do_reset();
    prio_vec = {2'd3, 2'd0, 2'd0, 2'd0};
    instr(4, 1, 0, 0);
    chk(ack == 1 && ack_id == 0, "R9", int'(ack), 1);
    finish_seq();
    instr(4, 1, 3, 0);
    chk(ack == 0 && pend[3] == 1, "R9", int'(ack), 0);
    pulse_ei();
    instr(4, 0, 0, 0);
    chk(ack == 1 && ack_id == 3, "R9", int'(ack_id), 3);

    // R6: register access hold in the final clock
    do_reset();
    instr(6, 1, 0, 1);
    chk(ack == 0, "R6", int'(ack), 0);
    chk(pend[0] == 1, "R6", int'(pend[0]), 1);
    instr(4, 0, 0, 0);
    chk(ack == 1 && ack_id == 0, "R6", int'(ack), 1);

    // R7: masking
    do_reset();
    mask = 4'b0010;
    instr(4, 1, 1, 0);
    chk(ack == 0 && pend[1] == 1, "R7", int'(ack), 0);
    mask = '0;
    instr(4, 0, 0, 0);
    chk(ack == 1 && ack_id == 1, "R7", int'(ack_id), 1);

    // R8: priority and ties
    do_reset();
    prio_vec = {2'd0, 2'd2, 2'd2, 2'd1};
    @(negedge clk); idle(); req_set = 4'b1111;
    @(negedge clk); idle();
    instr(4, 0, 0, 0);
    chk(ack == 1 && ack_id == 1, "R8", int'(ack_id), 1);
    finish_seq(); pulse_reti();
    instr(4, 0, 0, 0);
    chk(ack == 1 && ack_id == 2, "R8", int'(ack_id), 2);
    finish_seq(); pulse_reti();
    instr(4, 0, 0, 0);
    chk(ack == 1 && ack_id == 0, "R8", int'(ack_id), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule